// File: doc/BRIEF.md
# Entropy Health-Test Alarm Monitor

This block sits beside a random source and checks it all the time. It takes the raw bit stream, one qualified bit per cycle, and the output words the source produces. On these it runs four checks: two run-length limits on identical consecutive bits, a check for two equal words in a row, and a count of ones over fixed-size blocks. Two further failure flags, from statistical tests computed outside the block, come in as single-cycle pulses.

Each failure sets a sticky bit in an 8-bit status word. Software clears a bit by writing a 1 to it. Every failure event also advances a saturating alarm counter. When an event arrives while that counter already stands at a programmable threshold, a shutdown-overflow bit is raised. An enable word with the same bit layout as the status word selects which failures drive the single interrupt line. The status word also has a ready bit, which each accepted output word sets.

Top module: `entropy_health_mon`

## Requirements
- R1: The status bits are laid out as follows: bit 7 monobit failure, bit 6 poker failure, bit 5 long run, bit 4 run failure, bit 3 noise run, bit 2 stuck output, bit 1 shutdown overflow, bit 0 ready. Once set, a bit stays set until it is cleared by a write.
- R2: When a valid bit is the 34th identical bit in a row, status bit 5 is set one clock later. A run of 33 does not set it.
- R3: When a valid bit is the 48th identical bit in a row, status bit 3 is set one clock later. A run of 47 does not set it.
- R4: When an accepted word equals the word accepted before it, status bit 2 is set. The first word after reset never sets it.
- R5: Valid bits are grouped into blocks of 20,000, counted from reset. At the last bit of each block, the number of ones in the block is compared with the band 9,655 to 10,345 inclusive. A count outside the band sets status bit 7. No earlier bit of a block sets it.
- R6: A pulse on poker_fail_in sets status bit 6. A pulse on run_fail_in sets status bit 4.
- R7: Every cycle with word_valid high sets status bit 0.
- R8: When sts_clr_we is high, every status bit whose wdata bit is 1 is cleared, and bits whose wdata bit is 0 are left as they are. A bit that is set and cleared in the same cycle ends up set.
- R9: irq is the OR of status bits 7 to 1, each ANDed with the enable bit at the same position. Enables are loaded from wdata[7:1] when ctrl_we is high. Status bit 0 never drives irq.
- R10: A cycle with at least one failure event (the sources of bits 7 to 2) raises alarm_cnt by one while alarm_cnt is below the threshold. If alarm_cnt is already at or above the threshold, that cycle sets status bit 1 instead. The threshold loads from wdata when thr_we is high. Clearing bit 1 through a write also zeroes alarm_cnt.
- R11: After reset, status is 0, irq is 0, alarm_cnt is 0, all enables are 0 and the threshold is 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid | input | 1 | Qualifies bit_in |
| bit_in | input | 1 | Raw entropy bit |
| word_valid | input | 1 | Qualifies word_in |
| word_in | input | WORD_W | Generator output word |
| poker_fail_in | input | 1 | External poker-test failure pulse |
| run_fail_in | input | 1 | External runs-test failure pulse |
| sts_clr_we | input | 1 | Write-one-to-clear strobe for status |
| ctrl_we | input | 1 | Load strobe for interrupt enables |
| thr_we | input | 1 | Load strobe for alarm threshold |
| wdata | input | 8 | Write data shared by the three strobes |
| status | output | 8 | Sticky status word |
| irq | output | 1 | Interrupt request |
| alarm_cnt | output | 8 | Current alarm counter value |

## Verification
A wrong run-length count or a wrong block position stays hidden for a long time. It shows only when a run reaches 34 or 48, or when a block of 20,000 bits closes, and then it appears as a status bit set one bit too early or too late. For that reason the bench checks the status word both one bit before each threshold and exactly at it. A wrong alarm counter shows on alarm_cnt in the cycle after any failure, and it shifts the cycle in which bit 1 rises. A stale enable or status bit appears on irq one clock after the write that should have changed it.

// File: rtl/ehm_pkg.sv
package ehm_pkg;
    localparam int ST_W       = 8;
    localparam int B_MONO     = 7;
    localparam int B_POKER    = 6;
    localparam int B_LONG     = 5;
    localparam int B_RUNT     = 4;
    localparam int B_NOISE    = 3;
    localparam int B_STUCK    = 2;
    localparam int B_SHUT     = 1;
    localparam int B_READY    = 0;
    localparam int FAIL_LO    = 2;  // lowest bit counted as a failure event
endpackage

// File: rtl/ehm_runlen.sv
module ehm_runlen #(
    parameter int LONG_RUN  = 34,
    parameter int NOISE_RUN = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic long_evt,
    output logic noise_evt
);
    localparam int LW = $clog2(NOISE_RUN + 1);
    localparam logic [LW-1:0] LEN_MAX  = LW'(NOISE_RUN);
    localparam logic [LW-1:0] LEN_LONG = LW'(LONG_RUN);
    localparam logic [LW-1:0] LEN_ONE  = LW'(1);

    typedef struct packed {
        logic          last;
        logic [LW-1:0] len;   // 0 means no bit seen yet
    } rl_t;

    rl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        long_evt  = 1'b0;
        noise_evt = 1'b0;
        if (bit_valid) begin
            st_d.last = bit_in;
            if (st_q.len != '0 && bit_in == st_q.last) begin
                if (st_q.len != LEN_MAX) begin
                    st_d.len = st_q.len + 1'b1;
                end
            end else begin
                st_d.len = LEN_ONE;
            end
            long_evt  = (st_d.len == LEN_LONG) && (st_q.len != LEN_LONG);
            noise_evt = (st_d.len == LEN_MAX)  && (st_q.len != LEN_MAX);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ehm_monobit.sv
module ehm_monobit #(
    parameter int BLOCK_BITS = 20000,
    parameter int ONES_LO    = 9655,
    parameter int ONES_HI    = 10345
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_valid,
    input  logic bit_in,
    output logic fail_evt
);
    localparam int CW = $clog2(BLOCK_BITS + 1);
    localparam logic [CW-1:0] POS_LAST = CW'(BLOCK_BITS - 1);
    localparam logic [CW-1:0] LO_LIM   = CW'(ONES_LO);
    localparam logic [CW-1:0] HI_LIM   = CW'(ONES_HI);

    typedef struct packed {
        logic [CW-1:0] pos;
        logic [CW-1:0] ones;
    } mb_t;

    mb_t           st_d, st_q;
    logic [CW-1:0] ones_n;

    always_comb begin
        st_d     = st_q;
        fail_evt = 1'b0;
        ones_n   = st_q.ones + CW'(bit_in);
        if (bit_valid) begin
            if (st_q.pos == POS_LAST) begin
                fail_evt  = (ones_n < LO_LIM) || (ones_n > HI_LIM);
                st_d.pos  = '0;
                st_d.ones = '0;
            end else begin
                st_d.pos  = st_q.pos + 1'b1;
                st_d.ones = ones_n;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ehm_stuck.sv
module ehm_stuck #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    output logic              stuck_evt
);
    typedef struct packed {
        logic              have;
        logic [WORD_W-1:0] prev;
    } sk_t;

    sk_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        stuck_evt = 1'b0;
        if (word_valid) begin
            stuck_evt = st_q.have && (word_in == st_q.prev);
            st_d.have = 1'b1;
            st_d.prev = word_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/entropy_health_mon.sv
module entropy_health_mon #(
    parameter int WORD_W     = 32,
    parameter int LONG_RUN   = 34,
    parameter int NOISE_RUN  = 48,
    parameter int BLOCK_BITS = 20000,
    parameter int ONES_LO    = 9655,
    parameter int ONES_HI    = 10345,
    parameter int THR_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_in,
    input  logic              poker_fail_in,
    input  logic              run_fail_in,
    input  logic              sts_clr_we,
    input  logic              ctrl_we,
    input  logic              thr_we,
    input  logic [7:0]        wdata,
    output logic [7:0]        status,
    output logic              irq,
    output logic [THR_W-1:0]  alarm_cnt
);
    import ehm_pkg::*;

    localparam logic [THR_W-1:0] THR_RST = {THR_W{1'b1}};

    typedef struct packed {
        logic [ST_W-1:0]  sts;
        logic [ST_W-1:1]  en;
        logic [THR_W-1:0] thr;
        logic [THR_W-1:0] cnt;
    } mon_t;

    mon_t            st_d, st_q;
    logic            long_evt, noise_evt, mono_evt, stuck_evt;
    logic [ST_W-1:0] set_v, clr_v;
    logic            alarm;
    logic [ST_W-1:1] irq_terms;
    logic [THR_W-1:0] thr_q;

    ehm_runlen #(.LONG_RUN(LONG_RUN), .NOISE_RUN(NOISE_RUN)) u_runlen (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .long_evt(long_evt), .noise_evt(noise_evt)
    );

    ehm_monobit #(.BLOCK_BITS(BLOCK_BITS), .ONES_LO(ONES_LO), .ONES_HI(ONES_HI)) u_mono (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .fail_evt(mono_evt)
    );

    ehm_stuck #(.WORD_W(WORD_W)) u_stuck (
        .clk(clk), .rst_n(rst_n), .word_valid(word_valid), .word_in(word_in),
        .stuck_evt(stuck_evt)
    );

    always_comb begin
        st_d           = st_q;
        set_v          = '0;
        set_v[B_MONO]  = mono_evt;
        set_v[B_POKER] = poker_fail_in;
        set_v[B_LONG]  = long_evt;
        set_v[B_RUNT]  = run_fail_in;
        set_v[B_NOISE] = noise_evt;
        set_v[B_STUCK] = stuck_evt;
        set_v[B_READY] = word_valid;
        alarm          = |set_v[ST_W-1:FAIL_LO];
        clr_v          = sts_clr_we ? wdata : '0;

        if (alarm) begin
            if (st_q.cnt >= st_q.thr) set_v[B_SHUT] = 1'b1;
            else                      st_d.cnt = st_q.cnt + 1'b1;
        end
        if (clr_v[B_SHUT]) st_d.cnt = '0;

        // set has priority over a simultaneous clear
        st_d.sts = (st_q.sts & ~clr_v) | set_v;

        if (ctrl_we) st_d.en  = wdata[ST_W-1:1];
        if (thr_we)  st_d.thr = THR_W'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.sts <= '0;
            st_q.en  <= '0;
            st_q.thr <= THR_RST;
            st_q.cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar k = 1; k < ST_W; k++) begin : g_irq
        assign irq_terms[k] = st_q.sts[k] & st_q.en[k];
    end

    assign irq       = |irq_terms;
    assign status    = st_q.sts;
    assign alarm_cnt = st_q.cnt;
    assign thr_q     = st_q.thr;
endmodule

// File: rtl/ehm_checker.sv
module ehm_checker #(
    parameter int WORD_W = 32,
    parameter int THR_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sts_clr_we,
    input logic [7:0]        wdata,
    input logic              word_valid,
    input logic [WORD_W-1:0] word_in,
    input logic [7:0]        status,
    input logic              irq,
    input logic [THR_W-1:0]  alarm_cnt
);
    logic              seen_q;
    logic [WORD_W-1:0] last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= 1'b0;
            last_q <= '0;
        end else if (word_valid) begin
            seen_q <= 1'b1;
            last_q <= word_in;
        end
    end

    p_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((($past(status) & ~($past(sts_clr_we) ? $past(wdata) : 8'h00)) & ~status) == 8'h00));

    p_stuck_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && seen_q && word_in == last_q) |=> status[2]);

    p_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> status[0]);

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr_we && wdata[0] && !word_valid) |=> !status[0]);

    p_quiet_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7:1] == 7'h00) |-> !irq);

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_cnt != $past(alarm_cnt)) |->
            ((alarm_cnt == $past(alarm_cnt) + 1'b1) || (alarm_cnt == '0)));
endmodule

bind entropy_health_mon ehm_checker #(.WORD_W(WORD_W), .THR_W(THR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .sts_clr_we(sts_clr_we), .wdata(wdata),
    .word_valid(word_valid), .word_in(word_in), .status(status),
    .irq(irq), .alarm_cnt(alarm_cnt)
);

// File: tb/entropy_health_mon_tb.sv
module entropy_health_mon_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_valid = 1'b0, bit_in = 1'b0;
    logic          word_valid = 1'b0;
    logic [WW-1:0] word_in = '0;
    logic          poker_fail_in = 1'b0, run_fail_in = 1'b0;
    logic          sts_clr_we = 1'b0, ctrl_we = 1'b0, thr_we = 1'b0;
    logic [7:0]    wdata = '0;
    logic [7:0]    status;
    logic          irq;
    logic [7:0]    alarm_cnt;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    entropy_health_mon u_dut (
        .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
        .word_valid(word_valid), .word_in(word_in),
        .poker_fail_in(poker_fail_in), .run_fail_in(run_fail_in),
        .sts_clr_we(sts_clr_we), .ctrl_we(ctrl_we), .thr_we(thr_we),
        .wdata(wdata), .status(status), .irq(irq), .alarm_cnt(alarm_cnt)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        bit_valid = 0; word_valid = 0; poker_fail_in = 0; run_fail_in = 0;
        sts_clr_we = 0; ctrl_we = 0; thr_we = 0; wdata = '0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        bit_valid = 1'b1; bit_in = b;
        @(negedge clk);
        bit_valid = 1'b0;
    endtask

    task automatic send_word(input logic [WW-1:0] w);
        word_valid = 1'b1; word_in = w;
        @(negedge clk);
        word_valid = 1'b0;
    endtask

    task automatic clr_sts(input logic [7:0] m);
        sts_clr_we = 1'b1; wdata = m;
        @(negedge clk);
        sts_clr_we = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_thr(input logic [7:0] v);
        thr_we = 1'b1; wdata = v;
        @(negedge clk);
        thr_we = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk(status, 8'h00, "R11 status after reset");
        chk(irq, 1'b0, "R11 irq after reset");
        chk(alarm_cnt, 8'h00, "R11 alarm_cnt after reset");
    endtask

    task automatic t_long_run();
        do_reset();
        for (int i = 0; i < 33; i++) send_bit(1'b1);
        chk(status[5], 1'b0, "R2 run of 33 leaves bit5 clear");
        send_bit(1'b1);
        chk(status, 8'h20, "R2 run of 34 sets only bit5 (R1 map)");
        send_bit(1'b0);
        chk(status[5], 1'b1, "R1 bit5 sticky after run ends");
    endtask

    task automatic t_noise_run();
        do_reset();
        for (int i = 0; i < 47; i++) send_bit(1'b0);
        chk(status[3], 1'b0, "R3 run of 47 leaves bit3 clear");
        send_bit(1'b0);
        chk(status[3], 1'b1, "R3 run of 48 sets bit3");
    endtask

    task automatic t_stuck();
        do_reset();
        send_word(32'hA5A5_0001);
        chk(status[2], 1'b0, "R4 first word never stuck");
        send_word(32'h1234_5678);
        chk(status[2], 1'b0, "R4 differing word not stuck");
        send_word(32'h1234_5678);
        chk(status[2], 1'b1, "R4 repeated word sets bit2");
    endtask

    task automatic t_external();
        do_reset();
        poker_fail_in = 1'b1; @(negedge clk); poker_fail_in = 1'b0;
        chk(status, 8'h40, "R6 poker pulse sets bit6");
        run_fail_in = 1'b1; @(negedge clk); run_fail_in = 1'b0;
        chk(status, 8'h50, "R6 run pulse sets bit4");
    endtask

    task automatic t_ready_w1c();
        do_reset();
        send_word(32'h0000_0001);
        chk(status, 8'h01, "R7 word sets ready bit0");
        clr_sts(8'h00);
        chk(status, 8'h01, "R8 zero write leaves bits");
        word_valid = 1'b1; word_in = 32'h0000_0002;
        sts_clr_we = 1'b1; wdata = 8'h01;
        @(negedge clk);
        word_valid = 1'b0; sts_clr_we = 1'b0;
        chk(status[0], 1'b1, "R8 set wins over same-cycle clear");
        clr_sts(8'h01);
        chk(status[0], 1'b0, "R8 write 1 clears bit0");
        poker_fail_in = 1'b1; @(negedge clk); poker_fail_in = 1'b0;
        send_word(32'h0000_0002);
        send_word(32'h0000_0002);
        chk(status, 8'h45, "R8 setup bits 6,2,0");
        clr_sts(8'h40);
        chk(status, 8'h05, "R8 clearing bit6 keeps bits 2,0");
    endtask

    task automatic t_irq();
        do_reset();
        send_word(32'hCAFE_0000);
        send_word(32'hCAFE_0000);
        chk(irq, 1'b0, "R9 disabled failure gives no irq");
        wr_ctrl(8'h01);
        chk(irq, 1'b0, "R9 ready bit0 never drives irq");
        wr_ctrl(8'h04);
        chk(irq, 1'b1, "R9 enabled stuck bit raises irq");
        clr_sts(8'h04);
        chk(irq, 1'b0, "R9 irq drops after clear");
    endtask

    task automatic t_alarm();
        do_reset();
        wr_thr(8'd2);
        send_word(32'h0000_00AA);
        send_word(32'h0000_00AA);
        chk(alarm_cnt, 8'd1, "R10 first event counts");
        send_word(32'h0000_00AA);
        chk(alarm_cnt, 8'd2, "R10 second event counts");
        chk(status[1], 1'b0, "R10 no overflow at threshold");
        send_word(32'h0000_00AA);
        chk(status[1], 1'b1, "R10 event at threshold sets bit1");
        chk(alarm_cnt, 8'd2, "R10 counter holds at threshold");
        clr_sts(8'h02);
        chk(alarm_cnt, 8'd0, "R10 clearing bit1 zeroes counter");
        chk(status[1], 1'b0, "R10 bit1 cleared");
    endtask

    task automatic mono_block(input int n_ones, input logic exp_fail, input string what);
        for (int i = 0; i < 19999; i++) send_bit(i < n_ones);
        chk(status[7], 1'b0, {"R5 no verdict before block end ", what});
        send_bit(1'b0);
        chk(status[7], exp_fail, {"R5 verdict ", what});
        clr_sts(8'h80);
    endtask

    task automatic t_monobit();
        do_reset();
        mono_block(9654, 1'b1, "9654 ones");
        mono_block(9655, 1'b0, "9655 ones");
        mono_block(10345, 1'b0, "10345 ones");
        mono_block(10346, 1'b1, "10346 ones");
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        t_reset();
        t_long_run();
        t_noise_run();
        t_stuck();
        t_external();
        t_ready_w1c();
        t_irq();
        t_alarm();
        t_monobit();
        finish_run();
    end
endmodule